// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block sends a command frame of up to `DATA_W` bits from a reader to a tag over one carrier-enable line. Every bit opens with a fixed carrier-off gap. The carrier then stays on for long enough that the full bit period carries the bit value: a long period means one and a short period means zero. Bits go out least significant first. Before a bit is coded, it is XORed with a keystream bit taken from an outside whitening source. The block asks that source to advance with a one-cycle step pulse once per bit, during the carrier-on part of the bit.

All timing is measured in ticks of the `tick_en` strobe, which can arrive at any rate. After the last bit, one more carrier-off gap marks the end of the frame. At the same moment a free-running tick counter, `gap_ticks`, restarts from zero, so that the receive window that follows can be timed from it. After reset the carrier comes on and stays on for a charge interval before the block accepts its first frame.

Top module: `pw_frame_tx`

## Requirements
- R1: While reset is held, `carrier_on`=0, `busy`=1, `done`=0, `ks_step`=0 and `gap_ticks`=0. After reset is released, the carrier is on and `busy` stays high for exactly `CHARGE_TICKS` ticks. After that the block is idle: carrier on, `busy`=0.
- R2: A `start` seen while `busy` is low is accepted on that clock edge. From the next cycle `busy` is 1 and `carrier_on` is 0.
- R3: Every bit begins with the carrier off for exactly `PAUSE_TICKS` ticks.
- R4: After the gap, the carrier stays on for `ONE_TICKS-PAUSE_TICKS` ticks when the coded bit is 1 and for `ZERO_TICKS-PAUSE_TICKS` ticks when it is 0. Bit i of `data` is sent as the i-th bit, starting at bit 0.
- R5: The coded bit is the data bit XOR `ks_bit`. For bit i, `ks_bit` is the value present after i step pulses since the frame was accepted.
- R6: `ks_step` pulses for exactly one cycle per transmitted bit, only while the carrier is on inside a frame, and never at any other time.
- R7: After the last bit, one more carrier-off gap of `PAUSE_TICKS` ticks follows, and then the carrier returns on.
- R8: `done` is high for exactly one cycle, the first cycle after the trailing gap. In that cycle `busy`=0 and `carrier_on`=1.
- R9: `gap_ticks` is 0 in the cycle `done` is high. After that it rises by one for each tick and wraps at its width.
- R10: A `start` that arrives while `busy` is high, including during the charge interval, is ignored. The frame in flight keeps its data, length, timing and step count.
- R11: An `nbits` value above `DATA_W` sends `DATA_W` bits. An `nbits` of 0 sends only the trailing gap, with no step pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, taken when not busy |
| data | input | DATA_W | Frame bits, bit 0 sent first |
| nbits | input | LEN_W | Number of bits in the frame |
| tick_en | input | 1 | Timing strobe, one tick per high cycle |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Advance request to the keystream source |
| carrier_on | output | 1 | Carrier enable, 0 during gaps |
| busy | output | 1 | Charging or sending a frame |
| done | output | 1 | One-cycle frame end marker |
| gap_ticks | output | GAP_W | Ticks since the last frame end |

## Verification
The assertions assume three things about the inputs. `tick_en` is a strobe of any rate. `ks_bit` changes only after a `ks_step` pulse. A `start` may arrive at any time, including while busy. The bench keeps within these limits: it runs its tick generator at periods of one, two and three cycles, and it steps its own LFSR keystream only on `ks_step` at the falling clock edge. It measures every carrier-off and carrier-on stretch in ticks, so the check holds whatever the tick phase is when a frame starts. It also sends requests during the charge interval and in the middle of a frame to show that they are dropped.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

    typedef enum logic [2:0] {
        ST_CHARGE,
        ST_IDLE,
        ST_PAUSE,
        ST_HOLD,
        ST_TAIL
    } pwtx_state_e;

    typedef struct packed {
        pwtx_state_e state;
        logic        carrier;
        logic        air;
        logic        done;
        logic        step;
    } pwtx_regs_t;

endpackage

// File: rtl/pwtx_phase_timer.sv
module pwtx_phase_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // expire marks the tick that completes the current phase
    assign expire = tick_en && (cnt_q == limit_m1);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (tick_en)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwtx_shifter.sv
module pwtx_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:1] rest_in,
    input  logic [LEN_W-1:0]  nbits_in,
    output logic              next_bit,
    output logic              last,
    output logic              empty_req
);
    localparam int LEFT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-2:0] bits;
        logic [LEFT_W-1:0] left;
    } sh_t;

    sh_t              d, q;
    logic [LEFT_W-1:0] eff_len;

    // length request clamped to the register width
    always_comb begin
        if (int'(nbits_in) > DATA_W)
            eff_len = LEFT_W'(DATA_W);
        else
            eff_len = LEFT_W'(nbits_in);
    end

    assign empty_req = (nbits_in == '0);
    assign next_bit  = q.bits[0];
    assign last      = (q.left == LEFT_W'(1));

    always_comb begin
        d = q;
        if (load) begin
            d.bits = rest_in;
            d.left = eff_len;
        end else if (advance) begin
            d.bits = q.bits >> 1;
            d.left = q.left - LEFT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/pwtx_gap_timer.sv
module pwtx_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clear,
    output logic [GAP_W-1:0] count
);
    logic [GAP_W-1:0] gap_d, gap_q;

    assign count = gap_q;

    always_comb begin
        gap_d = gap_q;
        if (clear)
            gap_d = '0;
        else if (tick_en)
            gap_d = gap_q + GAP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else
            gap_q <= gap_d;
    end
endmodule

// File: rtl/pw_frame_tx.sv
module pw_frame_tx
    import pwtx_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int LEN_W        = 6,
    parameter int GAP_W        = 16,
    parameter int PAUSE_TICKS  = 30,
    parameter int ONE_TICKS    = 150,
    parameter int ZERO_TICKS   = 90,
    parameter int CHARGE_TICKS = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  nbits,
    input  logic              tick_en,
    input  logic              ks_bit,
    output logic              ks_step,
    output logic              carrier_on,
    output logic              busy,
    output logic              done,
    output logic [GAP_W-1:0]  gap_ticks
);
    localparam int MAX_TICKS  = (CHARGE_TICKS > ONE_TICKS) ? CHARGE_TICKS : ONE_TICKS;
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LIM_CHARGE = CNT_W'(CHARGE_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_PAUSE  = CNT_W'(PAUSE_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_ONE    = CNT_W'(ONE_TICKS - PAUSE_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_ZERO   = CNT_W'(ZERO_TICKS - PAUSE_TICKS - 1);

    pwtx_regs_t       d, q;
    logic             expire, tclr;
    logic [CNT_W-1:0] lim_m1;
    logic             load, adv, gap_clr;
    logic             next_bit, last, empty_req;

    pwtx_phase_timer #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .clear    (tclr),
        .limit_m1 (lim_m1),
        .expire   (expire)
    );

    pwtx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (adv),
        .rest_in   (data[DATA_W-1:1]),
        .nbits_in  (nbits),
        .next_bit  (next_bit),
        .last      (last),
        .empty_req (empty_req)
    );

    pwtx_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clear   (gap_clr),
        .count   (gap_ticks)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.step  = 1'b0;
        load    = 1'b0;
        adv     = 1'b0;
        gap_clr = 1'b0;
        lim_m1  = LIM_PAUSE;
        unique case (q.state)
            ST_CHARGE: begin
                d.carrier = 1'b1;
                lim_m1    = LIM_CHARGE;
                if (expire)
                    d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (start) begin
                    load      = 1'b1;
                    d.carrier = 1'b0;
                    d.air     = data[0] ^ ks_bit;
                    d.state   = empty_req ? ST_TAIL : ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                lim_m1 = LIM_PAUSE;
                if (expire) begin
                    d.carrier = 1'b1;
                    d.step    = 1'b1;
                    d.state   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                lim_m1 = q.air ? LIM_ONE : LIM_ZERO;
                if (expire) begin
                    d.carrier = 1'b0;
                    if (last) begin
                        d.state = ST_TAIL;
                    end else begin
                        adv     = 1'b1;
                        d.air   = next_bit ^ ks_bit;
                        d.state = ST_PAUSE;
                    end
                end
            end
            ST_TAIL: begin
                lim_m1 = LIM_PAUSE;
                if (expire) begin
                    d.carrier = 1'b1;
                    d.done    = 1'b1;
                    gap_clr   = 1'b1;
                    d.state   = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        // every phase change restarts the tick count
        tclr = (d.state != q.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_CHARGE;
        end else begin
            q <= d;
        end
    end

    assign carrier_on = q.carrier;
    assign ks_step    = q.step;
    assign done       = q.done;
    assign busy       = (q.state != ST_IDLE);
endmodule

// File: rtl/pwtx_chk.sv
module pwtx_chk #(
    parameter int GAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             carrier_on,
    input logic             done,
    input logic             ks_step,
    input logic [GAP_W-1:0] gap_ticks
);
    // R1
    idle_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> carrier_on);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !carrier_on));

    // R6
    step_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_step |-> (carrier_on && busy));

    // R6
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_step |=> !ks_step);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && carrier_on));

    // R9
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gap_ticks == '0));
endmodule

bind pw_frame_tx pwtx_chk #(.GAP_W(GAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .carrier_on (carrier_on),
    .done       (done),
    .ks_step    (ks_step),
    .gap_ticks  (gap_ticks)
);

// File: tb/sim_pw_frame_tx.sv
`timescale 1ns/1ps
module sim_pw_frame_tx;
    localparam int DW = 32;
    localparam int LW = 6;
    localparam int GW = 12;
    localparam int P  = 3;
    localparam int T1 = 10;
    localparam int T0 = 6;
    localparam int CH = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [LW-1:0] nbits_i = '0;
    logic          tick_en = 1'b0;
    logic          ks_bit;
    logic          ks_step, carrier_on, busy, done;
    logic [GW-1:0] gap_ticks;

    int   checks = 0;
    int   errors = 0;
    int   div = 2;
    int   ph = 0;
    logic [15:0] lfsr = 16'hACE1;

    bit   mon_on = 0;
    bit   car_prev = 1;
    int   seg = 0;
    int   nlow = 0, nhigh = 0, steps = 0;
    int   lows[64];
    int   highs[64];
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    assign ks_bit = lfsr[0];

    pw_frame_tx #(
        .DATA_W(DW), .LEN_W(LW), .GAP_W(GW), .PAUSE_TICKS(P),
        .ONE_TICKS(T1), .ZERO_TICKS(T0), .CHARGE_TICKS(CH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .data(data_i), .nbits(nbits_i),
        .tick_en(tick_en), .ks_bit(ks_bit), .ks_step(ks_step),
        .carrier_on(carrier_on), .busy(busy), .done(done), .gap_ticks(gap_ticks)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    // tick source, keystream source and carrier-segment monitor
    always @(negedge clk) begin
        ph      = (ph + 1 >= div) ? 0 : ph + 1;
        tick_en = (ph == 0);
        if (ks_step) lfsr = lfsr_next(lfsr);
        if (mon_on) begin
            if (ks_step) steps++;
            if (carrier_on != car_prev) begin
                if (car_prev) begin
                    if (nlow > 0 && nhigh < 64) begin highs[nhigh] = seg; nhigh++; end
                end else if (nlow < 64) begin
                    lows[nlow] = seg; nlow++;
                end
                seg      = int'(tick_en);
                car_prev = carrier_on;
            end else begin
                seg += int'(tick_en);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic nstep();
        @(negedge clk); #1;
    endtask

    task automatic run_frame(input int d_div, input logic [31:0] dat, input int n, input bit inject);
        logic [15:0] s;
        int ne, cyc, sum, lows_ok, hi_ok;
        div = d_div;
        nstep();
        nlow = 0; nhigh = 0; steps = 0; car_prev = 1; seg = 0; mon_on = 1;
        s = lfsr;
        data_i = dat; nbits_i = LW'(n); start = 1'b1;
        nstep();
        start = 1'b0;
        // R2: accepted, gap starts next cycle
        chk(busy && !carrier_on, "R2 accept", int'({busy, carrier_on}), 2);
        if (inject) begin
            repeat (15) nstep();
            // R10: request during a frame
            data_i = ~dat; nbits_i = LW'(5); start = 1'b1;
            nstep();
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 5000) begin nstep(); cyc++; end
        mon_on = 0;
        chk(done == 1'b1, "R8 done seen", int'(done), 1);
        chk(gap_ticks == '0 && !busy && carrier_on, "R9 gap zero at done", int'(gap_ticks), 0);
        ne = (n > DW) ? DW : n;
        // R3 R7 R11: one gap per bit plus the trailing gap
        chk(nlow == ne + 1, "R11 gap count", nlow, ne + 1);
        lows_ok = 1;
        for (int i = 0; i < nlow && i < 64; i++) if (lows[i] != P) lows_ok = 0;
        chk(lows_ok == 1, "R3 R7 gap width", (nlow > 0) ? lows[nlow-1] : -1, P);
        chk(nhigh == ne, "R4 bit count", nhigh, ne);
        hi_ok = 1;
        for (int i = 0; i < ne && i < nhigh; i++) begin
            int air, exp_w;
            air   = int'(dat[i] ^ s[0]);
            s     = lfsr_next(s);
            exp_w = air ? (T1 - P) : (T0 - P);
            if (highs[i] != exp_w) begin
                hi_ok = 0;
                $display("FAIL R4 R5 bit %0d: actual %0d expected %0d", i, highs[i], exp_w);
            end
        end
        chk(hi_ok == 1, "R5 coded bits", hi_ok, 1);
        chk(steps == ne, inject ? "R10 R6 step count" : "R6 step count", steps, ne);
        sum = 0;
        for (int k = 0; k < 6; k++) begin
            sum += int'(tick_en);
            nstep();
            if (k == 0) chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
            chk(int'(gap_ticks) == sum, "R9 gap count", int'(gap_ticks), sum);
        end
    endtask

    initial begin
        int sum, cyc;
        bit car_ok;
        repeat (4) nstep();
        // R1: reset values
        chk(!carrier_on && busy && !done && !ks_step && gap_ticks == '0,
            "R1 reset state", int'({carrier_on, busy, done, ks_step}), 4);
        rst_n = 1'b1;
        start = 1'b1;          // R10: request during charge
        sum = int'(tick_en);
        cyc = 0;
        car_ok = 1;
        while (cyc < 500) begin
            nstep();
            cyc++;
            if (!busy) break;
            if (!carrier_on) car_ok = 0;
            sum += int'(tick_en);
        end
        start = 1'b0;
        chk(sum == CH, "R1 charge ticks", sum, CH);
        chk(car_ok == 1, "R1 carrier during charge", int'(car_ok), 1);
        nstep();
        chk(!busy && carrier_on, "R10 start ignored in charge", int'({busy, carrier_on}), 1);

        for (int n = 0; n <= 34; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            run_frame(1 + (n % 3), seed, n, n == 20);
        end
        run_frame(2, 32'hFFFF_FFFF, 32, 0);
        run_frame(3, 32'h0000_0000, 32, 0);
        run_frame(1, 32'h5A5A_A5A5, 63, 0);
        run_frame(2, 32'h0000_0001, 1, 1);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end
endmodule